// File: doc/BRIEF.md
# General-purpose I/O port register slave

This block is the register side of a 32-line general-purpose I/O port. A bus master reaches it through a small request/acknowledge slave interface with 32-bit data and byte enables. The block holds the line values to drive and the per-line direction. It also samples the pads through a synchronizer. It keeps a 64-bit interrupt configuration word, an interrupt mask, an optional edge-select word and the interrupt status word. A read of the data word returns the driven value on output lines and the synchronized pad value on input lines.

Interrupt condition detection lives in a neighbouring block. That neighbour receives the configuration, mask, edge-select and direction outputs, and it pulses `irq_set` for each line that sees an event. This block ORs those pulses into the status word and clears status bits when the master writes ones to them.

The bus slave is a two-state machine. `ST_IDLE` waits for a request. The transition IDLE→ACK is taken when `bus_sel` is high: at that edge a write is committed or the read data is registered. `ST_ACK` raises `bus_ack` for exactly one cycle. The transition ACK→IDLE is always taken on the next edge, and `bus_sel` is not looked at in `ST_ACK`. The master keeps its request stable until it sees the acknowledge and then removes it.

Top module: `gpio_port`

## Requirements
- R1: After reset every stored word (data, direction, pad sample, configuration, mask, status, edge select) is 0, so `pad_oe`, `pad_out`, `bus_ack` and all interrupt outputs are 0.
- R2: A request seen in ST_IDLE is acknowledged with `bus_ack` high for exactly the next cycle, then the slave returns to ST_IDLE. `bus_rdata` is valid while `bus_ack` is high.
- R3: Word offset 0x00 holds the line data. A read returns (data AND direction) OR (pad sample AND NOT direction). A direction bit of 1 marks an output line.
- R4: Offset 0x04 holds the direction. `pad_oe` equals the direction and `pad_out` equals data AND direction. Both change at the edge that accepts the write, so they are already updated while `bus_ack` is high.
- R5: Pads pass through SYNC_STAGES flops and then into the pad sample register, which loads every clock. A read at offset 0x08 returns the sample AND NOT direction. A pad change made one cycle before a request is not yet seen by that read.
- R6: Offsets 0x0C and 0x10 are the low half (lines 0–15) and high half (lines 16–31) of the 64-bit `irq_cfg`, two bits per line. Both halves read back as written.
- R7: Offset 0x14 holds the interrupt mask. It reads back and drives `irq_mask`.
- R8: Status (offset 0x18, driven on `irq_status`) ORs in `irq_set` every cycle. A write clears each bit written as 1 and leaves bits written as 0. If a bit is set and cleared in the same cycle, the set wins.
- R9: With HAS_EDGE=1, offset 0x1C is a read/write edge-select word driven on `irq_edge`. With HAS_EDGE=0 that offset reads 0, writes to it do nothing, and `irq_edge` stays 0.
- R10: Only accesses with all four byte enables set are valid. Any other access is still acknowledged, but a write changes nothing and a read returns 0.
- R11: A read of an unmapped offset (0x20 and above, or an address not aligned to a word) returns 0, and a write to one changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access request, held until acknowledged |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_be | input | 4 | Byte enables; only all-ones is valid |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | One-cycle acknowledge |
| bus_rdata | output | 32 | Read data, valid with acknowledge |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Driven line values |
| pad_oe | output | 32 | Per-line output enable |
| irq_set | input | 32 | Per-line event pulses from the detector |
| irq_cfg | output | 64 | Two-bit-per-line interrupt configuration |
| irq_mask | output | 32 | Interrupt mask |
| irq_edge | output | 32 | Edge-select word (0 when absent) |
| irq_status | output | 32 | Interrupt status word |

## Verification
A corrupted data or direction bit appears on `pad_out` or `pad_oe` at the very acknowledge of the write that caused it. A status bit that was lost or left standing appears on `irq_status` one cycle after the offending set pulse or clear write. A synchronizer that is too short or too long changes which read first returns a new pad level, so reads are issued right after a pad change as well as after it has settled. A decode error is caught by reading back every offset after random writes and by comparing against a second instance built without the edge-select word.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int LINES  = 32;
    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;
    localparam int CFG_W  = 2 * LINES;

    // word offsets inside the port window
    localparam int OFS_DATA   = 'h00;
    localparam int OFS_DIR    = 'h04;
    localparam int OFS_PAD    = 'h08;
    localparam int OFS_CFG_LO = 'h0C;
    localparam int OFS_CFG_HI = 'h10;
    localparam int OFS_MASK   = 'h14;
    localparam int OFS_STAT   = 'h18;
    localparam int OFS_EDGE   = 'h1C;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_ACK  = 1'b1
    } bus_state_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[i] <= '0;
            else        stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_bus_fsm.sv
module gpio_bus_fsm
    import gpio_port_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    output logic accept,
    output logic ack
);

    bus_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (sel) state_d = ST_ACK;
            ST_ACK:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        accept = 1'b0;
        ack    = 1'b0;
        unique case (state_q)
            ST_IDLE: accept = sel;
            ST_ACK:  ack    = 1'b1;
        endcase
    end

    assert_ack_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    assert_accept_acked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ack);

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_port_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter bit HAS_EDGE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BE_W-1:0]   be,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LINES-1:0]  pad_sync,
    input  logic [LINES-1:0]  irq_set,
    output logic [DATA_W-1:0] rdata,
    output logic [LINES-1:0]  data_q,
    output logic [LINES-1:0]  dir_q,
    output logic [CFG_W-1:0]  cfg_q,
    output logic [LINES-1:0]  mask_q,
    output logic [LINES-1:0]  stat_q,
    output logic [LINES-1:0]  edge_q
);

    localparam int HALF = CFG_W / 2;

    logic             full;
    logic             wr_ok;
    logic [LINES-1:0] pad_q;
    logic [LINES-1:0] clr_mask;
    logic [DATA_W-1:0] rd_val;

    assign full  = (be == '1);
    assign wr_ok = accept && we && full;

    assign clr_mask = (wr_ok && addr == ADDR_W'(OFS_STAT)) ? wdata : '0;

    // read multiplexer; invalid strobes and holes read as zero
    always_comb begin
        rd_val = '0;
        if (full) begin
            case (addr)
                ADDR_W'(OFS_DATA):   rd_val = (data_q & dir_q) | (pad_q & ~dir_q);
                ADDR_W'(OFS_DIR):    rd_val = dir_q;
                ADDR_W'(OFS_PAD):    rd_val = pad_q & ~dir_q;
                ADDR_W'(OFS_CFG_LO): rd_val = cfg_q[HALF-1:0];
                ADDR_W'(OFS_CFG_HI): rd_val = cfg_q[CFG_W-1:HALF];
                ADDR_W'(OFS_MASK):   rd_val = mask_q;
                ADDR_W'(OFS_STAT):   rd_val = stat_q;
                ADDR_W'(OFS_EDGE):   rd_val = edge_q;
                default:             rd_val = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '0;
            cfg_q  <= '0;
            mask_q <= '0;
            stat_q <= '0;
            pad_q  <= '0;
            rdata  <= '0;
        end else begin
            pad_q  <= pad_sync;
            stat_q <= (stat_q & ~clr_mask) | irq_set;
            if (accept) rdata <= we ? '0 : rd_val;
            if (wr_ok) begin
                case (addr)
                    ADDR_W'(OFS_DATA):   data_q <= wdata;
                    ADDR_W'(OFS_DIR):    dir_q  <= wdata;
                    ADDR_W'(OFS_CFG_LO): cfg_q[HALF-1:0]     <= wdata;
                    ADDR_W'(OFS_CFG_HI): cfg_q[CFG_W-1:HALF] <= wdata;
                    ADDR_W'(OFS_MASK):   mask_q <= wdata;
                    default: ;
                endcase
            end
        end
    end

    if (HAS_EDGE) begin : g_edge
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                edge_q <= '0;
            else if (wr_ok && addr == ADDR_W'(OFS_EDGE)) edge_q <= wdata;
        end

        assert_edge_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (accept && we && be == '1 && addr == ADDR_W'(OFS_EDGE)) |=> edge_q == $past(wdata));
    end else begin : g_no_edge
        assign edge_q = '0;
    end

    assert_data_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && we && be == '1 && addr == ADDR_W'(OFS_DATA)) |=> data_q == $past(wdata));

    assert_stat_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && we && be == '1 && addr == ADDR_W'(OFS_STAT))
        |=> (stat_q & $past(wdata) & ~$past(irq_set)) == '0);

    assert_stat_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept && we && be == '1 && addr == ADDR_W'(OFS_STAT))
        |=> (stat_q & $past(stat_q)) == $past(stat_q));

    assert_partial_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && we && be != '1)
        |=> $stable(data_q) && $stable(dir_q) && $stable(cfg_q) && $stable(mask_q));

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int SYNC_STAGES = 2,
    parameter bit HAS_EDGE    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ack,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [LINES-1:0]  pad_in,
    output logic [LINES-1:0]  pad_out,
    output logic [LINES-1:0]  pad_oe,
    input  logic [LINES-1:0]  irq_set,
    output logic [CFG_W-1:0]  irq_cfg,
    output logic [LINES-1:0]  irq_mask,
    output logic [LINES-1:0]  irq_edge,
    output logic [LINES-1:0]  irq_status
);

    logic             accept;
    logic [LINES-1:0] pad_sync;
    logic [LINES-1:0] data_q;
    logic [LINES-1:0] dir_q;

    gpio_bus_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (bus_sel),
        .accept (accept),
        .ack    (bus_ack)
    );

    gpio_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (pad_sync)
    );

    gpio_regfile #(.ADDR_W(ADDR_W), .HAS_EDGE(HAS_EDGE)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .we       (bus_we),
        .addr     (bus_addr),
        .be       (bus_be),
        .wdata    (bus_wdata),
        .pad_sync (pad_sync),
        .irq_set  (irq_set),
        .rdata    (bus_rdata),
        .data_q   (data_q),
        .dir_q    (dir_q),
        .cfg_q    (irq_cfg),
        .mask_q   (irq_mask),
        .stat_q   (irq_status),
        .edge_q   (irq_edge)
    );

    assign pad_oe  = dir_q;
    assign pad_out = data_q & dir_q;

    assert_drive_follows_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && bus_we && bus_be == '1 && bus_addr == ADDR_W'(OFS_DIR))
        |=> pad_oe == $past(bus_wdata));

endmodule

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
    import gpio_port_pkg::*;

    localparam int AW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          sel = 1'b0, we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [3:0]    be = '0;
    logic [31:0]   wdata = '0, pad_in = '0, irq_set = '0;

    logic        ack, ne_ack;
    logic [31:0] rdata, ne_rdata, pad_out, ne_pad_out, pad_oe, ne_pad_oe;
    logic [63:0] irq_cfg, ne_cfg;
    logic [31:0] irq_mask, ne_mask, irq_edge, ne_edge, irq_status, ne_status;

    gpio_port #(.ADDR_W(AW), .SYNC_STAGES(2), .HAS_EDGE(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_we(we), .bus_addr(addr),
        .bus_be(be), .bus_wdata(wdata), .bus_ack(ack), .bus_rdata(rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq_set(irq_set),
        .irq_cfg(irq_cfg), .irq_mask(irq_mask), .irq_edge(irq_edge), .irq_status(irq_status)
    );

    gpio_port #(.ADDR_W(AW), .SYNC_STAGES(2), .HAS_EDGE(1'b0)) dut_ne (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_we(we), .bus_addr(addr),
        .bus_be(be), .bus_wdata(wdata), .bus_ack(ne_ack), .bus_rdata(ne_rdata),
        .pad_in(pad_in), .pad_out(ne_pad_out), .pad_oe(ne_pad_oe), .irq_set(irq_set),
        .irq_cfg(ne_cfg), .irq_mask(ne_mask), .irq_edge(ne_edge), .irq_status(ne_status)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] m_data = '0, m_dir = '0, m_pad = '0, m_mask = '0, m_stat = '0, m_edge = '0;
    logic [63:0] m_cfg = '0;

    task automatic chk(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic [AW-1:0] a, input logic [3:0] b, input bit he);
        if (b != 4'hF) return '0;
        case (a)
            6'h00:   return (m_data & m_dir) | (m_pad & ~m_dir);
            6'h04:   return m_dir;
            6'h08:   return m_pad & ~m_dir;
            6'h0C:   return m_cfg[31:0];
            6'h10:   return m_cfg[63:32];
            6'h14:   return m_mask;
            6'h18:   return m_stat;
            6'h1C:   return he ? m_edge : 32'h0;
            default: return '0;
        endcase
    endfunction

    task automatic check_outs(input string req);
        chk("R4", {req, " pad_oe"}, pad_oe, m_dir);
        chk("R4", {req, " pad_out"}, pad_out, m_data & m_dir);
        chk("R6", {req, " irq_cfg"}, irq_cfg, m_cfg);
        chk("R7", {req, " irq_mask"}, irq_mask, m_mask);
        chk("R8", {req, " irq_status"}, irq_status, m_stat);
        chk("R9", {req, " irq_edge"}, irq_edge, m_edge);
        chk("R9", {req, " irq_edge absent"}, ne_edge, 32'h0);
        chk("R8", {req, " status absent variant"}, ne_status, m_stat);
    endtask

    task automatic xfer(input bit w, input logic [AW-1:0] a, input logic [3:0] b,
                        input logic [31:0] d, input logic [31:0] s, input string req);
        logic [31:0] e, ene;
        @(negedge clk);
        sel = 1'b1; we = w; addr = a; be = b; wdata = d; irq_set = s;
        e   = exp_rd(a, b, 1'b1);
        ene = exp_rd(a, b, 1'b0);
        @(posedge clk);
        @(negedge clk);
        sel = 1'b0; irq_set = '0;
        chk("R2", "ack high", {63'h0, ack}, 64'h1);
        chk("R2", "ack high absent variant", {63'h0, ne_ack}, 64'h1);
        if (!w) begin
            chk(req, "rdata", rdata, e);
            chk(req, "rdata absent variant", ne_rdata, ene);
        end
        if (w && b == 4'hF) begin
            case (a)
                6'h00: m_data = d;
                6'h04: m_dir  = d;
                6'h0C: m_cfg[31:0]  = d;
                6'h10: m_cfg[63:32] = d;
                6'h14: m_mask = d;
                6'h18: m_stat = m_stat & ~d;
                6'h1C: m_edge = d;
                default: ;
            endcase
        end
        m_stat = m_stat | s;
        check_outs(req);
        @(posedge clk);
        @(negedge clk);
        chk("R2", "ack low after one cycle", {63'h0, ack}, 64'h0);
    endtask

    task automatic settle_pads(input logic [31:0] v);
        @(negedge clk);
        pad_in = v;
        repeat (5) @(negedge clk);
        m_pad = v;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20531));
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        chk("R1", "ack in reset", {63'h0, ack}, 64'h0);
        check_outs("R1");
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) xfer(1'b0, AW'(i * 4), 4'hF, '0, '0, "R1");

        // R3 R4 R5: mixed direction
        xfer(1'b1, 6'h04, 4'hF, 32'hFFFF_0000, '0, "R4");
        xfer(1'b1, 6'h00, 4'hF, 32'hA5A5_5A5A, '0, "R4");
        settle_pads(32'h1234_5678);
        xfer(1'b0, 6'h00, 4'hF, '0, '0, "R3");
        xfer(1'b0, 6'h08, 4'hF, '0, '0, "R5");
        // R5: a change one cycle before the request is not yet visible
        @(negedge clk);
        pad_in = 32'h0000_9ABC;
        xfer(1'b0, 6'h08, 4'hF, '0, '0, "R5");
        repeat (5) @(negedge clk);
        m_pad = 32'h0000_9ABC;
        xfer(1'b0, 6'h08, 4'hF, '0, '0, "R5");
        xfer(1'b1, 6'h04, 4'hF, 32'h0000_00FF, '0, "R4");
        xfer(1'b0, 6'h00, 4'hF, '0, '0, "R3");

        // R6 R7: configuration halves and mask
        xfer(1'b1, 6'h0C, 4'hF, 32'h1357_9BDF, '0, "R6");
        xfer(1'b1, 6'h10, 4'hF, 32'h2468_ACE0, '0, "R6");
        xfer(1'b0, 6'h0C, 4'hF, '0, '0, "R6");
        xfer(1'b0, 6'h10, 4'hF, '0, '0, "R6");
        xfer(1'b1, 6'h14, 4'hF, 32'hF0F0_0F0F, '0, "R7");
        xfer(1'b0, 6'h14, 4'hF, '0, '0, "R7");

        // R8: set, partial clear, set-wins-over-clear
        xfer(1'b0, 6'h00, 4'hF, '0, 32'h8000_0011, "R8");
        xfer(1'b0, 6'h18, 4'hF, '0, '0, "R8");
        xfer(1'b1, 6'h18, 4'hF, 32'h0000_0001, '0, "R8");
        xfer(1'b0, 6'h18, 4'hF, '0, '0, "R8");
        xfer(1'b1, 6'h18, 4'hF, 32'h8000_0010, 32'h0000_0010, "R8");
        xfer(1'b0, 6'h18, 4'hF, '0, '0, "R8");

        // R9: edge select present and absent
        xfer(1'b1, 6'h1C, 4'hF, 32'hDEAD_BEEF, '0, "R9");
        xfer(1'b0, 6'h1C, 4'hF, '0, '0, "R9");

        // R10: partial strobes
        xfer(1'b1, 6'h00, 4'h3, 32'hFFFF_FFFF, '0, "R10");
        xfer(1'b1, 6'h04, 4'hE, 32'hFFFF_FFFF, '0, "R10");
        xfer(1'b0, 6'h04, 4'h1, '0, '0, "R10");
        xfer(1'b0, 6'h00, 4'hF, '0, '0, "R10");

        // R11: holes and misaligned
        xfer(1'b1, 6'h20, 4'hF, 32'hFFFF_FFFF, '0, "R11");
        xfer(1'b1, 6'h06, 4'hF, 32'hFFFF_FFFF, '0, "R11");
        xfer(1'b1, 6'h3C, 4'hF, 32'hFFFF_FFFF, '0, "R11");
        xfer(1'b0, 6'h20, 4'hF, '0, '0, "R11");
        xfer(1'b0, 6'h05, 4'hF, '0, '0, "R11");
        xfer(1'b0, 6'h04, 4'hF, '0, '0, "R11");

        // constrained random mix
        for (int n = 0; n < 400; n++) begin
            int sel_kind;
            logic [AW-1:0] a;
            logic [3:0]    b;
            logic [31:0]   s;
            sel_kind = int'($urandom_range(0, 9));
            if (sel_kind < 8)       a = AW'(sel_kind * 4);
            else if (sel_kind == 8) a = AW'(32 + 4 * int'($urandom_range(0, 7)));
            else                    a = AW'(4 * int'($urandom_range(0, 7)) + int'($urandom_range(1, 3)));
            b = ($urandom_range(0, 7) == 0) ? 4'($urandom_range(0, 14)) : 4'hF;
            s = ($urandom_range(0, 3) == 0) ? $urandom() & $urandom() : 32'h0;
            if ($urandom_range(0, 9) == 0) settle_pads($urandom());
            xfer(1'($urandom_range(0, 1)), a, b, $urandom(), s, "R3");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule